// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one read or write burst request into a stream of column addresses, one per clock. A single-cycle start pulse captures a 9-bit starting column, a 3-bit length code and an ordering bit. From the next cycle on, the block presents a column address with a valid flag, and it marks the final beat with a last flag. Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned block that holds the starting column. They either count upward and wrap, or they XOR the beat number into the low bits. A full-page burst steps through all 512 columns and keeps going, wrapping from the top column back to zero, until a stop request ends it.

The controller drives the stop input to cut a burst short at any beat. The beat on which the stop is taken still carries a valid column and is flagged as last. A new start may arrive in any cycle, including the final beat of the running burst. The new burst then follows with no gap.

The block has two states. `SEQ_IDLE` means no burst is active. `SEQ_RUN` means a beat is being presented. The transitions are: IDLE→RUN on start; RUN→RUN on start (restart) or while beats remain; RUN→IDLE on the final beat or on stop, when no start arrives in the same cycle.

Top module: `sdram_col_seq`

## Requirements
- R1: While reset is held and after reset, before any start, `valid_o` and `last_o` are low.
- R2: The cycle after a start pulse, `valid_o` is high and `col_o` equals the captured starting column, for every length and ordering.
- R3: Length code `len_code_i` gives 000=1, 001=2, 010=4 and 011=8 beats. The codes 100, 101 and 110 behave as 1 beat. `valid_o` stays high for exactly that many consecutive cycles.
- R4: With `ilv_i`=0 and a fixed length BL, beat i outputs the start column with its low log2(BL) bits replaced by (start+i) mod BL. The upper bits stay unchanged.
- R5: With `ilv_i`=1 and a fixed length BL, beat i outputs the start column with its low log2(BL) bits replaced by (start XOR i).
- R6: Code 111 selects full page. Beat i outputs (start+i) mod 512 whatever the value of `ilv_i`. The burst continues past 512 beats and never raises `last_o` on its own.
- R7: `last_o` is high only together with `valid_o`, and it is high on the final beat of a fixed-length burst.
- R8: A stop (`stop_i`=1) during a beat makes `last_o` high in that same cycle. `valid_o` is low the next cycle unless a start arrives. A stop while idle has no effect.
- R9: A start during any beat, including the last one, makes the next cycle beat 0 of the new burst with no idle cycle between the two.
- R10: When start and stop arrive in the same cycle, the start wins and the new burst begins the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle burst start; captures the column, length and ordering |
| start_col_i | input | COL_W | Starting column |
| len_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | Ordering: 0 sequential, 1 interleave |
| stop_i | input | 1 | Ends the running burst at the current beat |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | The current beat is the final one |

## Verification
The hardest case to reach is the wrap of a full-page burst from column 511 to column 0, followed by correct behaviour past the 512th beat. No fixed-length burst ever gets there. The stimulus starts a full-page burst two columns below the top with the interleave bit set. It then holds the burst for more than a full page of beats and checks every address, confirming that `last_o` stays low, before stopping the burst with `stop_i`. Restarts on the final beat and start-with-stop collisions are placed by driving inputs on the exact beat count.

// File: rtl/col_seq_pkg.sv
package col_seq_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    localparam logic [2:0] LEN_CODE_FULL = 3'b111;

    // log2 of the fixed burst length; reserved codes fall back to one beat
    function automatic int unsigned len_log2(input logic [2:0] code);
        unique case (code)
            3'b001:  return 1;
            3'b010:  return 2;
            3'b011:  return 3;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/col_seq_beat_ctr.sv
module col_seq_beat_ctr #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    output logic [COL_W-1:0] beat
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat <= '0;
        end else if (clr) begin
            beat <= '0;
        end else if (adv) begin
            beat <= beat + 1'b1;
        end
    end

endmodule

// File: rtl/col_seq_order.sv
module col_seq_order #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] mask,
    input  logic [COL_W-1:0] beat,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] low_bits;

    always_comb begin
        low_bits = ilv ? (base ^ beat) : (base + beat);
        col      = (base & ~mask) | (low_bits & mask);
    end

endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             ilv_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o
);
    import col_seq_pkg::*;

    localparam logic [COL_W-1:0] FULL_MASK = '1;

    seq_state_e       state_q, state_d;
    logic [COL_W-1:0] base_q, mask_q, mask_d, beat;
    logic             ilv_q, full_q, full_d, at_end, running;

    always_comb begin
        full_d = (len_code_i == LEN_CODE_FULL);
        mask_d = full_d ? FULL_MASK
                        : COL_W'((32'd1 << len_log2(len_code_i)) - 32'd1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
            ilv_q  <= 1'b0;
            full_q <= 1'b0;
        end else if (start_i) begin
            base_q <= start_col_i;
            mask_q <= mask_d;
            ilv_q  <= ilv_i && !full_d;
            full_q <= full_d;
        end
    end

    assign running = (state_q == SEQ_RUN);
    assign at_end  = !full_q && (beat == mask_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (start_i) state_d = SEQ_RUN;
            SEQ_RUN: begin
                if (start_i)                 state_d = SEQ_RUN;
                else if (stop_i || at_end)   state_d = SEQ_IDLE;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    col_seq_beat_ctr #(.COL_W(COL_W)) u_beat (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (start_i),
        .adv  (running),
        .beat (beat)
    );

    col_seq_order #(.COL_W(COL_W)) u_order (
        .base(base_q),
        .mask(mask_q),
        .beat(beat),
        .ilv (ilv_q),
        .col (col_o)
    );

    // outputs
    always_comb begin
        valid_o = 1'b0;
        last_o  = 1'b0;
        unique case (state_q)
            SEQ_IDLE: ;
            SEQ_RUN: begin
                valid_o = 1'b1;
                last_o  = at_end || stop_i;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/col_seq_chk.sv
module col_seq_chk #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic             stop_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o
);

    a_r2_start_gives_beat: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> valid_o);

    a_r2_first_col: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (col_o == $past(start_col_i)));

    a_r7_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    a_r8_stop_marks_last: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && stop_i) |-> last_o);

    a_r8_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o);

    a_r3_no_gap_mid_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> valid_o);

    a_r1_idle_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && !start_i) |=> !valid_o);

endmodule

bind sdram_col_seq col_seq_chk #(.COL_W(COL_W)) u_col_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .start_col_i(start_col_i),
    .stop_i     (stop_i),
    .col_o      (col_o),
    .valid_o    (valid_o),
    .last_o     (last_o)
);

// File: tb/test_sdram_col_seq.sv
module test_sdram_col_seq;

    localparam int COL_W = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       len_code_i = '0;
    logic             ilv_i = 1'b0;
    logic             stop_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o, last_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    sdram_col_seq #(.COL_W(COL_W)) i_sdram_col_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .len_code_i(len_code_i), .ilv_i(ilv_i), .stop_i(stop_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
    );

    typedef struct packed {
        logic [8:0]      col;
        logic [2:0]      code;
        logic            ilv;
        logic [3:0]      n;
        logic [7:0][8:0] exp;   // exp[0] is beat 0
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VEC [NVEC] = '{
        '{9'd5,   3'b010, 1'b0, 4'd4, {9'd0,9'd0,9'd0,9'd0,9'd4,9'd7,9'd6,9'd5}},           // R4
        '{9'd5,   3'b010, 1'b1, 4'd4, {9'd0,9'd0,9'd0,9'd0,9'd6,9'd7,9'd4,9'd5}},           // R5
        '{9'd11,  3'b011, 1'b0, 4'd8, {9'd10,9'd9,9'd8,9'd15,9'd14,9'd13,9'd12,9'd11}},     // R4
        '{9'd11,  3'b011, 1'b1, 4'd8, {9'd12,9'd13,9'd14,9'd15,9'd8,9'd9,9'd10,9'd11}},     // R5
        '{9'd511, 3'b001, 1'b0, 4'd2, {9'd0,9'd0,9'd0,9'd0,9'd0,9'd0,9'd510,9'd511}},       // R4
        '{9'd510, 3'b001, 1'b1, 4'd2, {9'd0,9'd0,9'd0,9'd0,9'd0,9'd0,9'd511,9'd510}},       // R5
        '{9'd100, 3'b000, 1'b0, 4'd1, {9'd0,9'd0,9'd0,9'd0,9'd0,9'd0,9'd0,9'd100}},         // R3
        '{9'd77,  3'b101, 1'b1, 4'd1, {9'd0,9'd0,9'd0,9'd0,9'd0,9'd0,9'd0,9'd77}}           // R3 reserved
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive a start at a negedge; returns at the negedge where beat 0 is visible
    task automatic launch(input logic [8:0] c, input logic [2:0] code, input logic ilv);
        start_i = 1'b1; start_col_i = c; len_code_i = code; ilv_i = ilv;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!valid_o && !last_o, "R1 in reset", {valid_o, last_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!valid_o && !last_o, "R1 after reset", {valid_o, last_o}, 0);

        // R8: stop while idle does nothing
        stop_i = 1'b1; @(negedge clk); stop_i = 1'b0; @(negedge clk);
        chk(!valid_o, "R8 idle stop", valid_o, 0);

        // table walk: R2 R3 R4 R5 R7
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            launch(VEC[v].col, VEC[v].code, VEC[v].ilv);
            for (int b = 0; b < int'(VEC[v].n); b++) begin
                chk(valid_o, "R3 valid", valid_o, 1);
                chk(col_o == VEC[v].exp[b], (b == 0) ? "R2 first col" : "R4/R5 col",
                    col_o, VEC[v].exp[b]);
                chk(last_o == (b == int'(VEC[v].n) - 1), "R7 last", last_o,
                    (b == int'(VEC[v].n) - 1));
                @(negedge clk);
            end
            chk(!valid_o, "R3 burst length", valid_o, 0);
        end

        // R6: full page from 510 with ilv set, past 512 beats, then stop
        @(negedge clk);
        launch(9'd510, 3'b111, 1'b1);
        for (int b = 0; b < 530; b++) begin
            chk(valid_o && col_o == 9'((510 + b) % 512) && !last_o, "R6 full page",
                col_o, (510 + b) % 512);
            @(negedge clk);
        end
        stop_i = 1'b1; #1;
        chk(valid_o && last_o, "R8 stop last", {valid_o, last_o}, 3);
        @(negedge clk); stop_i = 1'b0;
        chk(!valid_o, "R8 stop ends", valid_o, 0);

        // R8: stop a burst of 8 at beat 2
        @(negedge clk);
        launch(9'd32, 3'b011, 1'b0);
        @(negedge clk); @(negedge clk);
        stop_i = 1'b1; #1;
        chk(last_o && col_o == 9'd34, "R8 stop mid burst", col_o, 34);
        @(negedge clk); stop_i = 1'b0;
        chk(!valid_o, "R8 stop mid ends", valid_o, 0);

        // R9: restart on the last beat of a 2-beat burst
        @(negedge clk);
        launch(9'd0, 3'b001, 1'b0);
        @(negedge clk);
        chk(last_o, "R9 last beat", last_o, 1);
        launch(9'd20, 3'b000, 1'b0);
        chk(valid_o && col_o == 9'd20 && last_o, "R9 back to back", col_o, 20);
        @(negedge clk);
        chk(!valid_o, "R9 single ends", valid_o, 0);

        // R10: start and stop together in mid burst
        @(negedge clk);
        launch(9'd40, 3'b011, 1'b0);
        stop_i = 1'b1;
        launch(9'd200, 3'b010, 1'b1);
        stop_i = 1'b0;
        chk(valid_o && col_o == 9'd200, "R10 start wins", col_o, 200);
        @(negedge clk);
        chk(valid_o && col_o == 9'd201, "R10 new burst runs", col_o, 201);

        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule